// File: doc/BRIEF.md
# EEPROM Write Sequencer with Acknowledge Polling

This block sits on the master side of an I2C bus. It takes one write request for a serial EEPROM and turns it into a series of commands for a byte-level I2C master. A request carries a control byte, a word address and up to `DATA_BYTES` data bytes. The byte-level master does all of the bit-level signalling. This block only chooses which bus command comes next and reacts to the ACK or NACK status that each byte returns.

A write ends with a Stop, and that Stop starts the target's internal programming cycle. The sequencer does not wait a fixed delay after it. It starts polling at once. Each poll is a Start followed by the same control byte that opened the write, with the direction bit at 0. A NACK leads to another Start and the same byte. An ACK means the programming cycle has finished.

After a successful poll the sequencer does one of two things, chosen per request:
- It closes the bus with a Stop.
- It leaves the transaction open so that the next queued command can follow with a repeated Start.

A programmable poll limit turns an endless busy target into an error. A NACK during the write itself is also reported as an error.

Top module: `ackpoll_write_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `pollFail` and `cmdValid` are all low.
- R2: A request is taken only when `reqValid` is high in a cycle where `busy` is low, and `busy` rises in the next cycle. While `busy` is high, `reqValid` and every request field are ignored: the command stream reflects only the accepted request.
- R3: The write phase issues these commands in order, using the command encoding Start=0, Write=1, Stop=2:
  - Start.
  - Write of the control byte with bit 0 forced to 0.
  - The address bytes, most significant byte first.
  - Data bytes 0 up to `reqLen`-1, where byte k is `reqData[8k+7:8k]` and a `reqLen` above `DATA_BYTES` counts as `DATA_BYTES`.
  - Stop.
- R4: Every command after the first is presented (`cmdValid` high) in the cycle right after the response to the previous command. In particular, the first poll's Start follows the response to the write Stop with no idle cycles.
- R5: Every Write that directly follows a Start carries the same byte within one request. The poll control byte is therefore identical to the write control byte.
- R6: A NACK on a poll control byte is followed by another Start and control byte, with no Stop between them.
- R7: On a poll ACK with `reqKeepOpen`=0, one Stop is issued and then `done` is raised. With `reqKeepOpen`=1, `done` is raised with no Stop, leaving the bus open.
- R8: If `cfgMaxPolls` (captured at accept) is nonzero and that many polls are NACKed, a Stop is issued and `pollFail` is raised. A value of 0 means polling never gives up.
- R9: A NACK on any byte of the write phase ends the request with a Stop and `pollFail`, and no polling follows.
- R10: `done` and `pollFail` are mutually exclusive one-cycle pulses. Each appears in the cycle after the final response, and `busy` is low in that cycle. `busy` stays high in every cycle from the one after accept up to and including the final response cycle.
- R11: Only one command is in flight at a time. While `cmdValid` is high and `cmdReady` is low, `cmdOp` and `cmdByte` hold steady. No new command is presented between a handshake and its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request present |
| reqCtrl | input | 8 | Control byte; bit 0 is sent as 0 |
| reqAddr | input | 8*ADDR_BYTES | Word address, sent most significant byte first |
| reqData | input | 8*DATA_BYTES | Data bytes, byte 0 in the low bits |
| reqLen | input | clog2(DATA_BYTES+1) | Number of data bytes |
| reqKeepOpen | input | 1 | 1: leave the bus open after a successful poll |
| cfgMaxPolls | input | POLL_W | Poll limit, 0 = unlimited |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: target acknowledged a poll |
| pollFail | output | 1 | One-cycle pulse: write NACK or poll limit reached |
| cmdValid | output | 1 | Command offered to the byte master |
| cmdOp | output | 2 | 0 Start, 1 Write, 2 Stop |
| cmdByte | output | 8 | Byte to send with a Write |
| cmdReady | input | 1 | Byte master takes the command |
| rspValid | input | 1 | Command finished |
| rspAck | input | 1 | 1 = ACK received for a Write |

## Verification
A response given in cycle w shows up in cycle w+1, either as the next command on `cmdValid` or as `done`/`pollFail`. The `busy` rise follows the accept cycle by exactly one cycle. The bench drives its inputs on the falling edge and samples outputs there. It stamps each response with its cycle number and then checks that the next command or the end pulse shows up exactly one cycle later. It also checks that `busy` never drops in between. The response latency and the `cmdReady` gaps vary between runs, so these one-cycle relations are tested under both back-to-back and stalled handshakes.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  // Byte-master command encoding
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_STOP  = 2'd2
  } busOpE;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WSTART,
    S_WCTRL,
    S_WPAY,
    S_WSTOP,
    S_PSTART,
    S_PCTRL,
    S_PSTOP,
    S_ESTOP
  } seqStateE;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture request
    logic advance;   // move to next payload byte
    logic pollStep;  // one more NACKed poll
    logic selCtrl;   // transmit control byte instead of payload
  } dpStrobeS;

endpackage

// File: rtl/ackpoll_dp.sv
module ackpoll_dp
  import ackpoll_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4,
  parameter int POLL_W     = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dpStrobeS                        stb,
  input  logic [7:0]                      reqCtrl,
  input  logic [8*ADDR_BYTES-1:0]         reqAddr,
  input  logic [8*DATA_BYTES-1:0]         reqData,
  input  logic [$clog2(DATA_BYTES+1)-1:0] reqLen,
  input  logic                            reqKeepOpen,
  input  logic [POLL_W-1:0]               cfgMaxPolls,
  output logic [7:0]                      txByte,
  output logic                            payLast,
  output logic                            pollLimit,
  output logic                            keepOpen
);

  localparam int LEN_W     = $clog2(DATA_BYTES + 1);
  localparam int PAY_BYTES = ADDR_BYTES + DATA_BYTES;
  localparam int PAY_W     = 8 * PAY_BYTES;
  localparam int CNT_W     = $clog2(PAY_BYTES + 1);

  logic [7:0]        ctrlQ;
  logic [PAY_W-1:0]  payQ;
  logic [PAY_W-1:0]  payNext;
  logic [CNT_W-1:0]  remQ;
  logic [CNT_W-1:0]  remInit;
  logic [LEN_W-1:0]  lenEff;
  logic [POLL_W-1:0] pollQ;
  logic [POLL_W-1:0] maxQ;
  logic              keepQ;

  // Payload leaves from the top byte: address MSB first, then data byte 0 up
  for (genvar i = 0; i < ADDR_BYTES; i++) begin : gAddr
    assign payNext[PAY_W-1-8*i -: 8] = reqAddr[8*(ADDR_BYTES-1-i) +: 8];
  end
  for (genvar k = 0; k < DATA_BYTES; k++) begin : gData
    assign payNext[PAY_W-1-8*(ADDR_BYTES+k) -: 8] = reqData[8*k +: 8];
  end

  always_comb begin
    lenEff  = (reqLen > LEN_W'(DATA_BYTES)) ? LEN_W'(DATA_BYTES) : reqLen;
    remInit = CNT_W'(ADDR_BYTES) + CNT_W'(lenEff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      payQ  <= '0;
      remQ  <= '0;
      pollQ <= '0;
      maxQ  <= '0;
      keepQ <= 1'b0;
    end else if (stb.load) begin
      ctrlQ <= reqCtrl & 8'hFE;
      payQ  <= payNext;
      remQ  <= remInit;
      pollQ <= '0;
      maxQ  <= cfgMaxPolls;
      keepQ <= reqKeepOpen;
    end else begin
      if (stb.advance) begin
        payQ <= payQ << 8;
        remQ <= remQ - CNT_W'(1);
      end
      if (stb.pollStep) begin
        pollQ <= pollQ + POLL_W'(1);
      end
    end
  end

  assign txByte    = stb.selCtrl ? ctrlQ : payQ[PAY_W-1 -: 8];
  assign payLast   = (remQ == CNT_W'(1));
  assign pollLimit = (maxQ != '0) && (pollQ == maxQ - POLL_W'(1));
  assign keepOpen  = keepQ;

endmodule

// File: rtl/ackpoll_fsm.sv
module ackpoll_fsm
  import ackpoll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cmdReady,
  input  logic       rspValid,
  input  logic       rspAck,
  input  logic       payLast,
  input  logic       pollLimit,
  input  logic       keepOpen,
  output dpStrobeS   stb,
  output logic       cmdValid,
  output logic [1:0] cmdOp,
  output logic       busy,
  output logic       done,
  output logic       pollFail
);

  seqStateE state, stateN;
  logic     waitQ, waitN;
  logic     doneQ, doneN;
  logic     failQ, failN;
  logic     rspIn;
  busOpE    opSel;

  assign rspIn = waitQ && rspValid;

  always_comb begin
    stateN = state;
    waitN  = waitQ;
    doneN  = 1'b0;
    failN  = 1'b0;
    if (state == S_IDLE) begin
      if (reqValid) begin
        stateN = S_WSTART;
        waitN  = 1'b0;
      end
    end else if (!waitQ) begin
      if (cmdReady) waitN = 1'b1;
    end else if (rspValid) begin
      waitN = 1'b0;
      unique case (state)
        S_WSTART: stateN = S_WCTRL;
        S_WCTRL:  stateN = rspAck ? S_WPAY : S_ESTOP;
        S_WPAY: begin
          if (!rspAck)      stateN = S_ESTOP;
          else if (payLast) stateN = S_WSTOP;
          else              stateN = S_WPAY;
        end
        S_WSTOP:  stateN = S_PSTART;
        S_PSTART: stateN = S_PCTRL;
        S_PCTRL: begin
          if (rspAck) begin
            if (keepOpen) begin
              stateN = S_IDLE;
              doneN  = 1'b1;
            end else begin
              stateN = S_PSTOP;
            end
          end else begin
            stateN = pollLimit ? S_ESTOP : S_PSTART;
          end
        end
        S_PSTOP: begin
          stateN = S_IDLE;
          doneN  = 1'b1;
        end
        S_ESTOP: begin
          stateN = S_IDLE;
          failN  = 1'b1;
        end
        default: stateN = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      waitQ <= 1'b0;
      doneQ <= 1'b0;
      failQ <= 1'b0;
    end else begin
      state <= stateN;
      waitQ <= waitN;
      doneQ <= doneN;
      failQ <= failN;
    end
  end

  always_comb begin
    unique case (state)
      S_WSTART, S_PSTART:          opSel = OP_START;
      S_WSTOP, S_PSTOP, S_ESTOP:   opSel = OP_STOP;
      default:                     opSel = OP_WRITE;
    endcase
  end

  assign cmdOp    = opSel;
  assign cmdValid = (state != S_IDLE) && !waitQ;
  assign busy     = (state != S_IDLE);
  assign done     = doneQ;
  assign pollFail = failQ;

  assign stb.load     = (state == S_IDLE) && reqValid;
  assign stb.advance  = (state == S_WPAY) && rspIn && rspAck && !payLast;
  assign stb.pollStep = (state == S_PCTRL) && rspIn && !rspAck;
  assign stb.selCtrl  = (state == S_WCTRL) || (state == S_PCTRL);

endmodule

// File: rtl/ackpoll_write_seq.sv
module ackpoll_write_seq
  import ackpoll_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4,
  parameter int POLL_W     = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  input  logic [7:0]                      reqCtrl,
  input  logic [8*ADDR_BYTES-1:0]         reqAddr,
  input  logic [8*DATA_BYTES-1:0]         reqData,
  input  logic [$clog2(DATA_BYTES+1)-1:0] reqLen,
  input  logic                            reqKeepOpen,
  input  logic [POLL_W-1:0]               cfgMaxPolls,
  output logic                            busy,
  output logic                            done,
  output logic                            pollFail,
  output logic                            cmdValid,
  output logic [1:0]                      cmdOp,
  output logic [7:0]                      cmdByte,
  input  logic                            cmdReady,
  input  logic                            rspValid,
  input  logic                            rspAck
);

  dpStrobeS stb;
  logic     payLast;
  logic     pollLimit;
  logic     keepOpen;

  ackpoll_fsm uFsm (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .cmdReady  (cmdReady),
    .rspValid  (rspValid),
    .rspAck    (rspAck),
    .payLast   (payLast),
    .pollLimit (pollLimit),
    .keepOpen  (keepOpen),
    .stb       (stb),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .busy      (busy),
    .done      (done),
    .pollFail  (pollFail)
  );

  ackpoll_dp #(
    .ADDR_BYTES (ADDR_BYTES),
    .DATA_BYTES (DATA_BYTES),
    .POLL_W     (POLL_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqCtrl     (reqCtrl),
    .reqAddr     (reqAddr),
    .reqData     (reqData),
    .reqLen      (reqLen),
    .reqKeepOpen (reqKeepOpen),
    .cfgMaxPolls (cfgMaxPolls),
    .txByte      (cmdByte),
    .payLast     (payLast),
    .pollLimit   (pollLimit),
    .keepOpen    (keepOpen)
  );

endmodule

// File: rtl/ackpoll_write_seq_chk.sv
module ackpoll_write_seq_chk
  import ackpoll_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       busy,
  input logic       done,
  input logic       pollFail,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic [7:0] cmdByte,
  input logic       cmdReady,
  input logic       rspValid
);

  logic       inFlight;
  logic       afterStart;
  logic       haveRef;
  logic [7:0] ctrlRef;
  logic       taken;

  assign taken = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight   <= 1'b0;
      afterStart <= 1'b0;
      haveRef    <= 1'b0;
      ctrlRef    <= '0;
    end else begin
      if (taken)         inFlight <= 1'b1;
      else if (rspValid) inFlight <= 1'b0;
      if (taken) begin
        afterStart <= (cmdOp == OP_START);
        if (cmdOp == OP_WRITE && afterStart && !haveRef) begin
          ctrlRef <= cmdByte;
          haveRef <= 1'b1;
        end
      end
      if (!busy) haveRef <= 1'b0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid); // R2

  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid)); // R2

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdOp) && $stable(cmdByte)); // R11

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !cmdValid); // R11

  AST_SAME_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    taken && cmdOp == OP_WRITE && afterStart && haveRef |-> cmdByte == ctrlRef); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pollFail |=> !pollFail); // R10

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(done && pollFail)); // R10

  AST_END_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (done || pollFail) |-> !busy); // R10

  AST_END_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (done || pollFail) |-> $past(rspValid)); // R10

endmodule

bind ackpoll_write_seq ackpoll_write_seq_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .busy     (busy),
  .done     (done),
  .pollFail (pollFail),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdByte  (cmdByte),
  .cmdReady (cmdReady),
  .rspValid (rspValid)
);

// File: tb/ackpoll_write_seq_test.sv
`timescale 1ns/1ps
module ackpoll_write_seq_test;

  localparam int AB = 2;
  localparam int DB = 4;
  localparam int PW = 8;
  localparam int OPS = 0, OPW = 1, OPP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          reqValid = 1'b0;
  logic [7:0]    reqCtrl = '0;
  logic [8*AB-1:0] reqAddr = '0;
  logic [8*DB-1:0] reqData = '0;
  logic [2:0]    reqLen = '0;
  logic          reqKeepOpen = 1'b0;
  logic [PW-1:0] cfgMaxPolls = '0;
  logic busy, done, pollFail, cmdValid;
  logic [1:0] cmdOp;
  logic [7:0] cmdByte;
  logic cmdReady = 1'b0, rspValid = 1'b0, rspAck = 1'b0;

  ackpoll_write_seq #(.ADDR_BYTES(AB), .DATA_BYTES(DB), .POLL_W(PW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCtrl(reqCtrl),
    .reqAddr(reqAddr), .reqData(reqData), .reqLen(reqLen),
    .reqKeepOpen(reqKeepOpen), .cfgMaxPolls(cfgMaxPolls), .busy(busy),
    .done(done), .pollFail(pollFail), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdByte(cmdByte), .cmdReady(cmdReady), .rspValid(rspValid), .rspAck(rspAck)
  );

  int vectors = 0, errors = 0;
  bit aborted = 0;

  // scenario
  int cLen, cKeep, cMax, cNacks, cNackW, cLat, cReadyMode;
  logic [7:0] cCtrl;
  logic [8*AB-1:0] cAddr;
  logic [8*DB-1:0] cData;
  bit go = 0, fin = 0, inOp = 0;

  int cyc = 0;
  int logN;
  int logOp[64];
  int logByte[64];
  int expN, expOut;
  int expOp[64];
  int expByte[64];
  int wIdx, cnt, gapErr, busyGap, outcome, rspWin, endWin;
  bit pend, pendAck, gapPend;

  function automatic int effLen(int l);
    return (l > DB) ? DB : l;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Byte-master model: drives inputs on the falling edge
  always @(negedge clk) if (rstN) begin
    cyc++;
    if (inOp) begin
      if (gapPend && !cmdValid && !done && !pollFail) gapErr++;
      gapPend = 0;
      if (done || pollFail) begin
        outcome = done ? 1 : 2;
        endWin = cyc;
        inOp = 0;
        fin = 1;
        reqValid = 1'b0;
      end else if (!busy) begin
        busyGap++;
      end
    end
    rspValid = 1'b0;
    if (pend) begin
      if (cnt == 1) begin
        rspValid = 1'b1;
        rspAck = pendAck;
        pend = 0;
        rspWin = cyc;
        gapPend = 1;
      end else cnt--;
    end
    cmdReady = (cReadyMode != 0) ? ((cyc % 3) == 2) : 1'b1;
    if (inOp && cmdValid && cmdReady) begin
      if (logN < 64) begin
        logOp[logN] = int'(cmdOp);
        logByte[logN] = int'(cmdByte);
        logN++;
      end
      pendAck = 1'b1;
      if (cmdOp == 2'(OPW)) begin
        int w;
        w = 1 + AB + effLen(cLen);
        if (wIdx < w) pendAck = (wIdx != cNackW);
        else pendAck = ((wIdx - w) >= cNacks);
        wIdx++;
      end
      pend = 1;
      cnt = cLat;
    end
    if (inOp) begin
      // R2: fields changed while busy must not reach the bus
      reqCtrl = ~cCtrl;
      reqAddr = ~cAddr;
      reqData = ~cData;
      reqLen = 3'd1;
      reqKeepOpen = ~cKeep[0];
      cfgMaxPolls = 8'd1;
    end
    if (go && !inOp) begin
      reqCtrl = cCtrl;
      reqAddr = cAddr;
      reqData = cData;
      reqLen = 3'(cLen);
      reqKeepOpen = cKeep[0];
      cfgMaxPolls = PW'(cMax);
      reqValid = 1'b1;
      inOp = 1;
      go = 0;
      wIdx = 0; logN = 0; gapErr = 0; busyGap = 0; pend = 0; gapPend = 0;
      outcome = 0; rspWin = -10; endWin = -20;
    end
  end

  task automatic push(input int op, input int b);
    expOp[expN] = op;
    expByte[expN] = b;
    expN++;
  endtask

  task automatic run(input int len, input int keep, input int mx, input int nacks,
                     input int nackW, input int lat, input int rdy, input int seed);
    int c0, w, np, bad, seqBad;
    bit lim;
    string tag;
    if (aborted) return;
    cLen = len; cKeep = keep; cMax = mx; cNacks = nacks; cNackW = nackW;
    cLat = lat; cReadyMode = rdy;
    cCtrl = 8'hA1 | 8'(len << 1);
    cAddr = 16'h1234 + 16'(seed * 16'h00F1);
    cData = 32'h89AB_CD01 * 32'(seed + 1);
    c0 = int'(cCtrl & 8'hFE);
    // expected command list
    expN = 0; w = 0;
    push(OPS, 0);
    for (int i = 0; i < 1 + AB + effLen(len); i++) begin
      int b;
      if (i == 0) b = c0;
      else if (i <= AB) b = int'(cAddr[8*(AB-i) +: 8]);
      else b = int'(cData[8*(i-1-AB) +: 8]);
      if (nackW < 0 || i <= nackW) push(OPW, b);
    end
    push(OPP, 0);
    if (nackW >= 0) expOut = 2;
    else begin
      lim = (mx != 0) && (nacks >= mx);
      np = lim ? mx : nacks + 1;
      for (int j = 0; j < np; j++) begin push(OPS, 0); push(OPW, c0); end
      if (lim) begin push(OPP, 0); expOut = 2; end
      else begin if (keep == 0) push(OPP, 0); expOut = 1; end
    end
    go = 1;
    while (!fin) begin
      @(posedge clk);
      if (cyc > 190000) begin
        chk(1'b0, "watchdog", cyc, 190000);
        aborted = 1;
        return;
      end
    end
    fin = 0;
    tag = (nackW >= 0) ? "R9" : (nacks > 0 ? "R6" : "R3");
    // command sequence (R2 garbage fields must not appear)
    chk(logN == expN, {tag, "/R2 length"}, logN, expN);
    seqBad = 0;
    for (int i = 0; i < expN && i < logN; i++)
      if (logOp[i] != expOp[i] || (expOp[i] == OPW && logByte[i] != expByte[i])) begin
        if (seqBad == 0)
          chk(1'b0, {tag, " command"}, logOp[i]*256 + logByte[i],
              expOp[i]*256 + (expOp[i] == OPW ? expByte[i] : logByte[i]));
        seqBad++;
      end
    if (seqBad == 0) chk(1'b1, tag, 0, 0);
    bad = 0;
    for (int i = 1; i < logN; i++)
      if (logOp[i] == OPW && logOp[i-1] == OPS && logByte[i] != c0) bad++;
    chk(bad == 0, "R5 poll ctrl byte", bad, 0);
    chk(outcome == expOut, (mx != 0 && nacks >= mx && nackW < 0) ? "R8 outcome" : "R7 outcome",
        outcome, expOut);
    if (expOut == 1 && logN > 0)
      chk((logOp[logN-1] == OPP) == (keep == 0), "R7 final stop", logOp[logN-1], keep ? OPW : OPP);
    chk(endWin == rspWin + 1, "R10 end pulse timing", endWin - rspWin, 1);
    chk(busyGap == 0, "R10 busy held", busyGap, 0);
    chk(gapErr == 0, "R4 next command timing", gapErr, 0);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    int s;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pollFail && !cmdValid, "R1 in reset",
        {busy, done, pollFail, cmdValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !pollFail && !cmdValid, "R1 after reset",
        {busy, done, pollFail, cmdValid}, 0);
    s = 0;
    // sweep: length, close mode, poll limit, NACKed polls (R3 R6 R7 R8)
    for (int len = 0; len <= DB; len++)
      for (int keep = 0; keep < 2; keep++)
        for (int m = 0; m < 3; m++)
          for (int pn = 0; pn < 3; pn++) begin
            int mx, nk;
            mx = (m == 0) ? 0 : (m == 1 ? 2 : 4);
            nk = (pn == 2) ? 3 : pn;
            run(len, keep, mx, nk, -1, 1 + (len % 3), keep ^ (pn & 1), s);
            s++;
          end
    // R9 NACK on each write-phase byte
    for (int nw = 0; nw < 1 + AB + 2; nw++) begin
      run(2, 0, 3, 0, nw, 1 + (nw % 2), nw % 2, s);
      s++;
    end
    // R8 limits of one, unlimited polling
    run(1, 0, 1, 1, -1, 2, 0, s++);
    run(1, 1, 1, 0, -1, 1, 1, s++);
    run(3, 0, 0, 6, -1, 1, 0, s++);
    run(3, 1, 0, 5, -1, 3, 1, s++);
    // R3 length above DATA_BYTES clamps
    run(7, 0, 2, 0, -1, 1, 0, s++);
    run(5, 1, 2, 1, -1, 2, 1, s++);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule